// File: doc/BRIEF.md
# Segmented DAC switch decoder

This block converts an 8-bit sample into the switch-control word of a segmented current-steering digital-to-analog converter. The sample is registered on the rising clock edge. The five most significant bits are expanded into a 31-line thermometer code of equal-weight segments, each worth 8 LSB. The three least significant bits pass through unchanged as binary-weighted controls worth 1, 2 and 4 LSB. The resulting 34 controls are registered a second time so that every switch changes on the same edge.

Each control has a true drive and a complement drive. A unit that is not steered to the true output is steered to the complement output, so the two weighted sums always total 255 LSB. An active-high sleep input forces every drive low, which turns all current sources off. A synchronous reset clears both register stages to code 0, which puts full scale on the complement side.

Top module: `segdac_switch_decoder`

## Requirements
- R1: While reset is high at a rising edge, both stages are cleared. After that edge segTrue is 0, segComp is all ones, binTrue is 0 and binComp is 3'b111.
- R2: A code presented before rising edge N appears on the outputs after edge N+1. Values that the code input takes between edges have no effect.
- R3: segTrue[k] is 1 exactly when code[7:3] is greater than k, for k from 0 to 30. This gives a thermometer pattern that fills from bit 0.
- R4: binTrue[i] equals code[i] for i from 0 to 2, and bit i carries a weight of 2^i LSB.
- R5: When the block is awake, segComp is the bitwise inverse of segTrue and binComp is the bitwise inverse of binTrue.
- R6: The true weighted sum (8 per active segment plus binTrue) equals the code. The true and complement sums together equal 255.
- R7: On the step from code 7 to code 8, all three binary controls turn off and exactly one segment, segTrue[0], turns on.
- R8: When sleep is high at a rising edge and reset is low, all four output vectors are 0 after that edge.
- R9: After sleep is released, the outputs again follow the code with the R2 latency.
- R10: Code 255 sets every true control to 1 and every complement control to 0. Code 0 does the reverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep | input | 1 | Power-down request, active high |
| code | input | 8 | Sample code, bit 7 is the MSB |
| segTrue | output | 31 | Thermometer segment drives, true side |
| segComp | output | 31 | Thermometer segment drives, complement side |
| binTrue | output | 3 | Binary LSB drives, true side |
| binComp | output | 3 | Binary LSB drives, complement side |

## Verification
The latency and sum assertions compare the outputs with the code sampled two edges earlier. They are armed only after two consecutive edges without reset, so they rely on the code input being a clean, known value at each rising edge. The complement assertion assumes that sleep is also clean at each edge, and it stands down for one cycle after sleep was high. The stimulus changes code and sleep only on falling edges, except for one deliberate mid-cycle pulse. That pulse returns to the held value before the next rising edge, so every sampled value stays known.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
  typedef struct packed {
    logic clearAll;
    logic blankOut;
  } segdac_strobe_t;
endpackage

// File: rtl/segdac_ctrl.sv
module segdac_ctrl
  import segdac_pkg::*;
(
  input  logic           rst,
  input  logic           sleep,
  output segdac_strobe_t strobes
);
  always_comb begin
    strobes.clearAll = rst;
    strobes.blankOut = sleep & ~rst;
  end
endmodule

// File: rtl/segdac_datapath.sv
module segdac_datapath
  import segdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 3
) (
  input  logic                        clk,
  input  segdac_strobe_t              strobes,
  input  logic [CODE_W-1:0]           codeIn,
  output logic [(2**(CODE_W-BIN_W))-2:0] segTrue,
  output logic [(2**(CODE_W-BIN_W))-2:0] segComp,
  output logic [BIN_W-1:0]            binTrue,
  output logic [BIN_W-1:0]            binComp
);
  localparam int SEG_W   = CODE_W - BIN_W;
  localparam int SEG_N   = (2**SEG_W) - 1;
  localparam int SEG_WT  = 2**BIN_W;
  localparam int FULL    = (2**CODE_W) - 1;

  logic [CODE_W-1:0] codeReg;
  logic [SEG_W-1:0]  upperField;
  logic [SEG_N-1:0]  segNext;
  logic [1:0]        warmCnt;

  always_ff @(posedge clk) begin
    if (strobes.clearAll) codeReg <= '0;
    else                  codeReg <= codeIn;
  end

  assign upperField = codeReg[CODE_W-1:BIN_W];

  for (genvar k = 0; k < SEG_N; k++) begin : g_seg
    assign segNext[k] = (upperField > SEG_W'(k));
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      segTrue <= '0;
      segComp <= '1;
      binTrue <= '0;
      binComp <= '1;
    end else if (strobes.blankOut) begin
      segTrue <= '0;
      segComp <= '0;
      binTrue <= '0;
      binComp <= '0;
    end else begin
      segTrue <= segNext;
      segComp <= ~segNext;
      binTrue <= codeReg[BIN_W-1:0];
      binComp <= ~codeReg[BIN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll)  warmCnt <= 2'd0;
    else if (warmCnt != 2'd2) warmCnt <= warmCnt + 2'd1;
  end

  function automatic int weightOf(input logic [SEG_N-1:0] s, input logic [BIN_W-1:0] b);
    return $countones(s) * SEG_WT + int'(b);
  endfunction

  a_r1_reset_state: assert property (@(posedge clk)
    $past(strobes.clearAll) |-> (segTrue == '0 && segComp == '1 && binTrue == '0 && binComp == '1));

  a_r2_latency: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (warmCnt == 2'd2 && !$past(strobes.blankOut)) |-> (weightOf(segTrue, binTrue) == int'($past(codeIn, 2))));

  a_r3_thermometer: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (warmCnt != 2'd0) |-> ((segTrue & (segTrue + 1'b1)) == '0));

  a_r5_complement: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (warmCnt != 2'd0 && !$past(strobes.blankOut)) |-> (segComp == ~segTrue && binComp == ~binTrue));

  a_r6_full_sum: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (warmCnt != 2'd0 && !$past(strobes.blankOut)) |-> (weightOf(segTrue, binTrue) + weightOf(segComp, binComp) == FULL));

  a_r8_sleep_off: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (warmCnt != 2'd0 && $past(strobes.blankOut)) |-> (segTrue == '0 && segComp == '0 && binTrue == '0 && binComp == '0));
endmodule

// File: rtl/segdac_switch_decoder.sv
module segdac_switch_decoder
  import segdac_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int BIN_W  = 3,
  localparam int SEG_N = (2**(CODE_W-BIN_W)) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep,
  input  logic [CODE_W-1:0] code,
  output logic [SEG_N-1:0]  segTrue,
  output logic [SEG_N-1:0]  segComp,
  output logic [BIN_W-1:0]  binTrue,
  output logic [BIN_W-1:0]  binComp
);
  segdac_strobe_t strobes;

  segdac_ctrl u_ctrl (
    .rst     (rst),
    .sleep   (sleep),
    .strobes (strobes)
  );

  segdac_datapath #(.CODE_W(CODE_W), .BIN_W(BIN_W)) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .codeIn  (code),
    .segTrue (segTrue),
    .segComp (segComp),
    .binTrue (binTrue),
    .binComp (binComp)
  );
endmodule

// File: tb/segdac_switch_decoder_tb.sv
module segdac_switch_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep = 1'b0;
  logic [7:0] code = 8'd0;
  logic [30:0] segTrue, segComp;
  logic [2:0] binTrue, binComp;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  segdac_switch_decoder u_dut (
    .clk(clk), .rst(rst), .sleep(sleep), .code(code),
    .segTrue(segTrue), .segComp(segComp), .binTrue(binTrue), .binComp(binComp)
  );

  localparam int NVEC = 12;
  localparam logic [7:0] VEC_CODE [NVEC] = '{8'd0, 8'd1, 8'd7, 8'd8, 8'd15, 8'd64,
                                             8'd127, 8'd128, 8'd170, 8'd85, 8'd254, 8'd255};

  function automatic logic [30:0] thermo(input logic [4:0] u);
    logic [30:0] t = '0;
    for (int i = 0; i < 31; i++) if (u > i) t[i] = 1'b1;
    return t;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkCode(input string req, input logic [7:0] c);
    int tSum, cSum;
    tSum = $countones(segTrue) * 8 + int'(binTrue);
    cSum = $countones(segComp) * 8 + int'(binComp);
    check({req, " R3 segTrue"}, 64'(segTrue), 64'(thermo(c[7:3])));
    check({req, " R4 binTrue"}, 64'(binTrue), 64'(c[2:0]));
    check({req, " R5 complement"}, {segComp, binComp}, {~segTrue, ~binTrue});
    check({req, " R6 true sum"}, 64'(tSum), 64'(c));
    check({req, " R6 total"}, 64'(tSum + cSum), 64'd255);
  endtask

  task automatic applyCode(input logic [7:0] c);
    code = c;
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", {segTrue, segComp, binTrue, binComp}, {31'd0, {31{1'b1}}, 3'd0, 3'd7});
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) begin
      applyCode(VEC_CODE[i]);
      checkCode("vec", VEC_CODE[i]);
    end
    applyCode(8'd7);
    checkCode("R7 before", 8'd7);
    applyCode(8'd8);
    check("R7 step", {segTrue, binTrue}, {31'd1, 3'd0});
    applyCode(8'd255);
    check("R10 full true", {segTrue, segComp, binTrue, binComp}, {{31{1'b1}}, 31'd0, 3'd7, 3'd0});
    applyCode(8'd0);
    check("R10 full comp", {segTrue, segComp, binTrue, binComp}, {31'd0, {31{1'b1}}, 3'd0, 3'd7});
    code = 8'd100;
    @(posedge clk); @(negedge clk);
    check("R2 one edge still old", 64'(binTrue), 64'd0);
    @(posedge clk); @(negedge clk);
    checkCode("R2 latency", 8'd100);
    code = 8'd40;
    @(posedge clk);
    #2 code = 8'd200;
    #2 code = 8'd40;
    @(posedge clk); @(negedge clk);
    checkCode("R2 mid-cycle ignored", 8'd40);
    code = 8'd200;
    sleep = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 sleep", {segTrue, segComp, binTrue, binComp}, 68'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 sleep held", {segTrue, segComp, binTrue, binComp}, 68'd0);
    sleep = 1'b0;
    applyCode(8'd77);
    checkCode("R9 resume", 8'd77);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset again", {segTrue, segComp, binTrue, binComp}, {31'd0, {31{1'b1}}, 3'd0, 3'd7});
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule